// File: doc/BRIEF.md
# Threshold-Triggered Pulse Peak Capture

This block sits behind a fast ADC that digitizes the shaped output of a radiation detector front end. It watches a stream of 8-bit unsigned samples, stays idle until a sample reaches a programmable trigger level, and then keeps the largest sample seen. When the pulse falls back to the baseline region, it reports that largest sample as the event amplitude with a one-cycle strobe. It then re-arms straight away. There is no fixed hold period. A short pulse frees the block as soon as it ends, so slow and fast shaping times both work with the same logic.

A programmable timeout closes a capture that never returns to baseline, for example a pile-up tail or a drifting baseline. The block is built around a three-state controller. The states are ARMED (waiting for a trigger), TRACK (following the pulse) and REPORT (one cycle that presents the result). The transitions are:

- TRIGGER: ARMED to TRACK.
- SETTLE or EXPIRE: TRACK to REPORT.
- REARM: REPORT to ARMED.

The return-to-baseline limit is the baseline input plus a fixed hysteresis parameter, HYST, which defaults to 4.

Top module: `pkcap_top`

## Requirements
- R1: After reset, `busy` and `pk_valid` are 0 and `pk_value` is 0.
- R2: TRIGGER: in ARMED, a sample with `smp_vld`=1 and `smp_data` >= `thr_trig` starts a capture, and `busy` is 1 from the following cycle.
- R3: A cycle with `smp_vld`=0 has no effect on the capture, whatever `smp_data` holds: it neither triggers, nor raises the maximum, nor ends a capture.
- R4: The reported peak is the unsigned maximum of the trigger sample and every valid sample accepted in TRACK, including the sample that ends the capture.
- R5: SETTLE: in TRACK, a valid sample with `smp_data` <= `base_lvl` + HYST ends the capture. The sum is formed without wrap, so a sum above 255 accepts every sample. `pk_valid` is then 1 for exactly the one cycle after that edge.
- R6: EXPIRE: if the Nth valid sample after the trigger (N = `tmo_lim`) does not settle, the capture ends on that sample anyway. A `tmo_lim` of 0 behaves as 1.
- R7: `pk_value` changes only when a capture ends and holds its value until the next capture ends.
- R8: A sample that reaches the trigger level during TRACK, or during the REPORT cycle, does not start a new event. REARM always follows REPORT after one cycle.
- R9: `busy` is 1 in TRACK and REPORT and 0 in ARMED. `pk_valid` is 1 only in REPORT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 8 | Unsigned sample value |
| thr_trig | input | 8 | Trigger level |
| base_lvl | input | 8 | Baseline level |
| tmo_lim | input | 16 | Maximum number of tracked samples after the trigger |
| pk_value | output | 8 | Last captured peak |
| pk_valid | output | 1 | One-cycle strobe when a peak is reported |
| busy | output | 1 | Capture or report in progress |

## Verification
The hardest situation to reach is a sample that reaches the trigger level in the single REPORT cycle, because it must arrive on exactly the clock after the settling sample. The stimulus feeds one sample per clock, so it places a large value directly after the settling sample. With a small timeout it also follows an expired capture immediately with a high sample and then a trigger-level sample. This shows that the first is dropped and the second starts a fresh event. A baseline near full scale exercises the unwrapped settle limit. Strobe-low cycles carrying extreme values exercise R3.

// File: rtl/pkcap_pkg.sv
package pkcap_pkg;
    typedef enum logic [1:0] {
        S_ARMED  = 2'd0,
        S_TRACK  = 2'd1,
        S_REPORT = 2'd2
    } pk_state_t;
endpackage

// File: rtl/pkcap_levels.sv
module pkcap_levels #(
    parameter int DW   = 8,
    parameter int HYST = 4
) (
    input  logic [DW-1:0] smp,
    input  logic [DW-1:0] thr,
    input  logic [DW-1:0] base,
    output logic          hit_trig,
    output logic          at_base
);
    localparam int BW = DW + 1;

    logic [BW-1:0] lim;

    always_comb begin
        lim      = {1'b0, base} + BW'(HYST);
        hit_trig = (smp >= thr);
        at_base  = ({1'b0, smp} <= lim);
    end
endmodule

// File: rtl/pkcap_tracker.sv
module pkcap_tracker #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          upd,
    input  logic [DW-1:0] smp,
    output logic [DW-1:0] max_q,
    output logic [DW-1:0] max_nxt
);
    always_comb begin
        if (load)
            max_nxt = smp;
        else if (upd && (smp > max_q))
            max_nxt = smp;
        else
            max_nxt = max_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            max_q <= '0;
        else if (load || upd)
            max_q <= max_nxt;
    end

    AST_MAX_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !load) |=> (max_q >= $past(max_q))); // R4
endmodule

// File: rtl/pkcap_timer.sv
module pkcap_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [TMO_W-1:0] tmo,
    output logic             expired
);
    localparam int CW = TMO_W + 1;

    logic [TMO_W-1:0] cnt_q;
    logic [CW-1:0]    cnt_nxt;

    always_comb begin
        cnt_nxt = {1'b0, cnt_q} + CW'(1);
        expired = (cnt_nxt >= {1'b0, tmo});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (inc)
            cnt_q <= cnt_nxt[TMO_W-1:0];
    end
endmodule

// File: rtl/pkcap_top.sv
module pkcap_top #(
    parameter int DW    = 8,
    parameter int TMO_W = 16,
    parameter int HYST  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [DW-1:0]    smp_data,
    input  logic [DW-1:0]    thr_trig,
    input  logic [DW-1:0]    base_lvl,
    input  logic [TMO_W-1:0] tmo_lim,
    output logic [DW-1:0]    pk_value,
    output logic             pk_valid,
    output logic             busy
);
    import pkcap_pkg::*;

    pk_state_t     state_q, state_d;
    logic          hit_trig, at_base, expired;
    logic          load, upd, inc, cap;
    logic [DW-1:0] max_q, max_nxt;
    logic [DW-1:0] value_q;

    pkcap_levels #(.DW(DW), .HYST(HYST)) u_levels (
        .smp      (smp_data),
        .thr      (thr_trig),
        .base     (base_lvl),
        .hit_trig (hit_trig),
        .at_base  (at_base)
    );

    pkcap_tracker #(.DW(DW)) u_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .upd     (upd),
        .smp     (smp_data),
        .max_q   (max_q),
        .max_nxt (max_nxt)
    );

    pkcap_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (load),
        .inc     (inc),
        .tmo     (tmo_lim),
        .expired (expired)
    );

    // Next-state and control decode
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        upd     = 1'b0;
        inc     = 1'b0;
        cap     = 1'b0;
        unique case (state_q)
            S_ARMED: begin
                if (smp_vld && hit_trig) begin
                    load    = 1'b1;
                    state_d = S_TRACK;           // TRIGGER
                end
            end
            S_TRACK: begin
                if (smp_vld) begin
                    upd = 1'b1;
                    if (at_base || expired) begin
                        cap     = 1'b1;
                        state_d = S_REPORT;      // SETTLE / EXPIRE
                    end else begin
                        inc = 1'b1;
                    end
                end
            end
            S_REPORT: state_d = S_ARMED;         // REARM
            default:  state_d = S_ARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_ARMED;
        else
            state_q <= state_d;
    end

    // Result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            value_q <= '0;
        else if (cap)
            value_q <= max_nxt;
    end

    // Outputs
    always_comb begin
        pk_value = value_q;
        pk_valid = (state_q == S_REPORT);
        busy     = (state_q != S_ARMED);
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |=> !pk_valid); // R5
    AST_SETTLE_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pk_valid && smp_vld && at_base) |=> pk_valid); // R5
    AST_VALUE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !pk_valid |-> $stable(pk_value)); // R7
    AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |-> busy); // R9
    AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        pk_valid |=> !busy); // R8
endmodule

// File: tb/tb_pkcap_top.sv
module tb_pkcap_top;
    localparam int CLK_PERIOD = 10;
    localparam int HYST = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [7:0]  smp_data = '0;
    logic [7:0]  thr_trig = 8'd40;
    logic [7:0]  base_lvl = 8'd10;
    logic [15:0] tmo_lim = 16'd1000;
    logic [7:0]  pk_value;
    logic        pk_valid;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int exp_q[$];

    // reference state: 0 armed, 1 tracking, 2 reporting
    int m_state = 0;
    int m_max = 0;
    int m_cnt = 0;
    int m_value = 0;

    pkcap_top dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .smp_data (smp_data),
        .thr_trig (thr_trig),
        .base_lvl (base_lvl),
        .tmo_lim  (tmo_lim),
        .pk_value (pk_value),
        .pk_valid (pk_valid),
        .busy     (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference update for one clock edge
    task automatic model_edge(input logic v, input int d);
        int lim;
        int t;
        lim = int'(base_lvl) + HYST;
        t = (tmo_lim == 0) ? 1 : int'(tmo_lim);
        case (m_state)
            0: if (v && d >= int'(thr_trig)) begin
                   m_state = 1; m_max = d; m_cnt = 0;           // R2
               end
            1: if (v) begin
                   if (d > m_max) m_max = d;                     // R4
                   if (d <= lim || m_cnt + 1 >= t) begin         // R5 R6
                       m_state = 2; m_value = m_max;
                       exp_q.push_back(m_max);
                   end else begin
                       m_cnt++;
                   end
               end
            default: m_state = 0;                                // R8
        endcase
    endtask

    // Driver: one sample per clock
    task automatic drive(input logic v, input int d);
        @(negedge clk);
        check("R9 busy", int'(busy), (m_state != 0) ? 1 : 0);
        check("R9 pk_valid", int'(pk_valid), (m_state == 2) ? 1 : 0);
        check("R7 pk_value", int'(pk_value), m_value);
        smp_vld  = v;
        smp_data = d[7:0];
        model_edge(v, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 0);
    endtask

    // Monitor: scoreboard compare on each reported peak
    always @(negedge clk) begin
        if (rst_n && pk_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R8 unexpected report actual %0d expected none", pk_value);
            end else begin
                check("R4 peak", int'(pk_value), exp_q.pop_front());
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++; errors++;
                $display("FAIL watchdog actual %0d expected <20000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 pk_valid", int'(pk_valid), 0);
        check("R1 pk_value", int'(pk_value), 0);
        rst_n = 1'b1;
        idle(2);

        // R2 R4 R5: basic pulse, peak 120
        drive(1, 5); drive(1, 20); drive(1, 50);
        @(negedge clk); check("R2 busy after trigger", int'(busy), 1);
        drive(1, 90); drive(1, 120); drive(1, 100); drive(1, 60);
        drive(1, 30); drive(1, 12); idle(3);

        // R3: strobe-low samples ignored, peak 80
        drive(1, 45); drive(0, 200); drive(1, 80); drive(0, 3);
        drive(1, 60); drive(0, 255); drive(1, 9); idle(2);
        drive(0, 250); drive(0, 250);
        check("R3 no trigger while strobe low", int'(busy), 0);
        idle(2);

        // R4: unsigned compare, peak 240
        drive(1, 60); drive(1, 130); drive(1, 240); drive(1, 200); drive(1, 5);
        idle(2);

        // R8: retrigger during capture and in report cycle, peak 160
        drive(1, 50); drive(1, 100); drive(1, 30); drive(1, 70);
        drive(1, 160); drive(1, 8); drive(1, 200); drive(1, 3);
        idle(3);

        // R6: timeout of 4 tracked samples, peak 95, then fresh event 50
        tmo_lim = 16'd4;
        drive(1, 60); drive(1, 70); drive(1, 80); drive(1, 90); drive(1, 95);
        drive(1, 99); drive(1, 50); drive(1, 5); idle(2);

        // R6: zero timeout behaves as one, peak 100
        tmo_lim = 16'd0;
        drive(1, 45); drive(1, 100); idle(2);
        tmo_lim = 16'd1000;

        // R5: settle limit without wrap, peak 254
        base_lvl = 8'd253;
        drive(1, 200); drive(1, 254); idle(2);
        base_lvl = 8'd10;
        idle(4);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5 missing reports actual %0d expected 0", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule